// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Almost Flags

This block is a single-clock FIFO with two output timing modes, picked once after every master reset. In standard mode a word reaches the read data output only when it is requested. The read-side flag then says whether any word is stored, and the write-side flag says whether there is room. In fall-through mode the oldest word waits on the read data output. The read-side flag says that output is valid, so the first word written into an empty FIFO shows up with no read request. The write-side flag again says whether there is room.

Two more flags, both active low, warn when the FIFO is close to empty or close to full. Each is compared against a 10-bit offset supplied on input pins. An active-low master reset clears the storage pointers and forces a fixed set of flag levels.

After reset is released, a small start-up state machine counts two clock edges. It samples the mode pin on the second edge and then opens the write side.

State machine, one process for the state register and one for the next state:
- `ST_RESET`: entered asynchronously whenever `mrst_n` is low.
- `ST_RESET -> ST_ARM`: taken on the first rising edge with `mrst_n` high.
- `ST_ARM -> ST_RUN_STD`: taken on the second rising edge if `mode_std` is high.
- `ST_ARM -> ST_RUN_FWFT`: taken on the second rising edge if `mode_std` is low.
- `ST_RUN_STD` and `ST_RUN_FWFT`: each holds until the next reset.

Top module: `dual_mode_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rd_ready` is 0 once running, and no data written before the reset can be read.
- R2: While `mrst_n` is low, `wr_ready`, `rd_ready` and `ae_n` are 0 and `af_n` is 1.
- R3: `wr_ready` stays 0 after the first rising edge following reset release and becomes 1 after the second.
- R4: `mode_std` is sampled on the second rising edge after reset release, where 1 selects standard mode and 0 selects fall-through mode. Later changes of the pin have no effect until the next reset.
- R5: In standard mode, `rd_data` is 0 after reset and changes only on the edge of an accepted read, which loads the oldest word. `rd_ready` is 1 exactly when at least one word is stored. Words come out in write order.
- R6: In fall-through mode, a word written while `rd_ready` is 0 appears on `rd_data` on the same edge that raises `rd_ready`, with no read request.
- R7: In fall-through mode, `rd_data` holds the oldest word until a read is accepted. A read and a write in the same cycle each take effect, and order is kept.
- R8: `ae_n` is 0 while the stored word count (including the word shown in fall-through mode) is at or below `ae_ofs`, and 1 otherwise.
- R9: `af_n` is 0 while free space (depth minus stored count) is at or below `af_ofs`, and 1 otherwise.
- R10: With depth words stored, `wr_ready` is 0, and a write is ignored and stores nothing.
- R11: A read while `rd_ready` is 0 is ignored: `rd_data` and the read pointer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| mode_std | input | 1 | Mode select sampled after reset: 1 standard, 0 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Not-full (standard) or input-ready (fall-through) |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read data register |
| rd_ready | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| ae_ofs | input | OFS_W | Almost-empty offset |
| af_ofs | input | OFS_W | Almost-full offset |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
In fall-through mode, the refill of the output register from storage can fall in the same cycle as a write into storage. Also, a write into an empty FIFO can fall in the same cycle as a read request that must be ignored. The bench provokes the first case with one cycle that both writes and reads while three words are queued. It judges the result by the word shown next and by how many reads it then takes to drain the FIFO. It provokes the second case by holding `rd_en` high during a write into an empty FIFO, and expects the written word to appear on the output with `rd_ready` high.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_ARM      = 2'd1,
        ST_RUN_STD  = 2'd2,
        ST_RUN_FWFT = 2'd3
    } dmf_state_e;
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
    import dmf_pkg::*;
(
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       mode_std,
    output dmf_state_e state,
    output logic       running,
    output logic       fwft
);
    dmf_state_e state_nxt;

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) state <= ST_RESET;
        else         state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET:    state_nxt = ST_ARM;
            ST_ARM:      state_nxt = mode_std ? ST_RUN_STD : ST_RUN_FWFT;
            ST_RUN_STD:  state_nxt = ST_RUN_STD;
            ST_RUN_FWFT: state_nxt = ST_RUN_FWFT;
            default:     state_nxt = ST_RESET;
        endcase
    end

    always_comb begin
        running = (state == ST_RUN_STD) || (state == ST_RUN_FWFT);
        fwft    = (state == ST_RUN_FWFT);
    end
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              running,
    input  logic              fwft,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ready,
    output logic              rd_ready,
    output logic [CNT_W-1:0]  occ
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  ram_cnt;
    logic              out_valid;
    logic              wr_acc, need_load, ram_pop, ram_push, bypass;

    always_comb begin
        occ       = ram_cnt + (fwft ? CNT_W'(out_valid) : '0);
        wr_ready  = running && (occ != CNT_W'(DEPTH));
        rd_ready  = running && (fwft ? out_valid : (ram_cnt != '0));
        wr_acc    = wr_en && wr_ready;
        need_load = running && fwft && (!out_valid || rd_en);
        bypass    = need_load && (ram_cnt == '0) && wr_acc;
        ram_pop   = fwft ? (need_load && (ram_cnt != '0)) : (rd_en && rd_ready);
        ram_push  = wr_acc && !bypass;
    end

    always_ff @(posedge clk) begin
        if (ram_push) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            ram_cnt   <= '0;
            out_valid <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (ram_push) wptr <= wptr + 1'b1;
            if (ram_pop)  rptr <= rptr + 1'b1;
            ram_cnt <= ram_cnt + CNT_W'(ram_push) - CNT_W'(ram_pop);
            if (ram_pop)     rd_data <= mem[rptr];
            else if (bypass) rd_data <= wr_data;
            if (need_load)   out_valid <= ram_pop || bypass;
        end
    end
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
    parameter int CNT_W = 11,
    parameter int OFS_W = 10,
    localparam int DEPTH = 1 << (CNT_W - 1),
    localparam int CW = (CNT_W > OFS_W) ? CNT_W : OFS_W
) (
    input  logic             in_reset,
    input  logic [CNT_W-1:0] occ,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             ae_n,
    output logic             af_n
);
    logic [CW-1:0] used_w, free_w;

    always_comb begin
        used_w = CW'(occ);
        free_w = CW'(DEPTH) - used_w;
        ae_n   = !in_reset && (used_w > CW'(ae_ofs));
        af_n   = in_reset || (free_w > CW'(af_ofs));
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 10,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              mode_std,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic              ae_n,
    output logic              af_n
);
    dmf_state_e       state;
    logic             running, fwft;
    logic [CNT_W-1:0] occ;

    dmf_ctrl u_ctrl (
        .clk(clk), .mrst_n(mrst_n), .mode_std(mode_std),
        .state(state), .running(running), .fwft(fwft)
    );

    dmf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .mrst_n(mrst_n), .running(running), .fwft(fwft),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .wr_ready(wr_ready), .rd_ready(rd_ready), .occ(occ)
    );

    dmf_flags #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_flags (
        .in_reset(state == ST_RESET), .occ(occ),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_n(ae_n), .af_n(af_n)
    );
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker
    import dmf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              wr_en,
    input logic              wr_ready,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              ae_n,
    input logic              af_n,
    input logic [CNT_W-1:0]  occ,
    input dmf_state_e        state
);
    always @(posedge clk) begin
        if (mrst_n === 1'b0) begin
            AST_RESET_FLAGS: assert (!wr_ready && !rd_ready && !ae_n && af_n) else $error("reset flags"); // R2
        end
    end

    AST_READY_AFTER_ARM: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_ARM) |=> wr_ready) else $error("wr_ready late"); // R3

    AST_MODE_HELD_STD: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_RUN_STD) |=> (state == ST_RUN_STD)) else $error("mode changed"); // R4

    AST_MODE_HELD_FWFT: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_RUN_FWFT) |=> (state == ST_RUN_FWFT)) else $error("mode changed"); // R4

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_RUN_FWFT && !rd_ready && wr_en && wr_ready)
        |=> (rd_ready && rd_data == $past(wr_data))) else $error("first word"); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != ST_ARM && !wr_ready && wr_en && !rd_en) |=> $stable(occ)) else $error("overflow"); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != ST_ARM && !rd_ready && rd_en && !wr_en) |=> ($stable(occ) && $stable(rd_data))) else $error("underflow"); // R11
endmodule

bind dual_mode_fifo dmf_checker #(.DATA_W(DATA_W), .CNT_W(ADDR_W + 1)) u_chk (
    .clk(clk), .mrst_n(mrst_n), .wr_en(wr_en), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_en(rd_en), .rd_ready(rd_ready), .rd_data(rd_data),
    .ae_n(ae_n), .af_n(af_n), .occ(occ), .state(state)
);

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
    logic        clk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        mode_std = 1'b1;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [9:0]  ae_ofs = '0;
    logic [9:0]  af_ofs = '0;
    logic        wr_ready, rd_ready, ae_n, af_n;
    logic [35:0] rd_data;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dual_mode_fifo uut (
        .clk(clk), .mrst_n(mrst_n), .mode_std(mode_std),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_n(ae_n), .af_n(af_n)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [35:0] d, input bit r);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset(input bit m, input bit check);
        @(negedge clk);
        mrst_n = 1'b0; mode_std = m;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); @(negedge clk);
            if (check) begin
                chk("R2 wr_ready in reset", 36'(wr_ready), 36'd0);
                chk("R2 rd_ready in reset", 36'(rd_ready), 36'd0);
                chk("R2 ae_n in reset", 36'(ae_n), 36'd0);
                chk("R2 af_n in reset", 36'(af_n), 36'd1);
            end
        end
        mrst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        if (check) chk("R3 wr_ready after edge 1", 36'(wr_ready), 36'd0);
        @(posedge clk); @(negedge clk);
        if (check) chk("R3 wr_ready after edge 2", 36'(wr_ready), 36'd1);
        mode_std = !m;
    endtask

    task automatic t_reset;
        step(1'b1, 36'h5A, 1'b0);
        do_reset(1'b1, 1'b1);
        chk("R1 rd_ready empty after reset", 36'(rd_ready), 36'd0);
        chk("R1 ae_n after reset", 36'(ae_n), 36'd0);
        chk("R1 af_n after reset", 36'(af_n), 36'd1);
    endtask

    task automatic t_std;
        do_reset(1'b1, 1'b0);
        step(1'b1, 36'hA1, 1'b0);
        chk("R5 rd_ready after write", 36'(rd_ready), 36'd1);
        chk("R4 R5 no fall-through in std", rd_data, 36'h0);
        step(1'b1, 36'hA2, 1'b0);
        step(1'b1, 36'hA3, 1'b0);
        step(1'b0, 36'h0, 1'b1);
        chk("R5 read 1", rd_data, 36'hA1);
        step(1'b0, 36'h0, 1'b1);
        chk("R5 read 2", rd_data, 36'hA2);
        step(1'b0, 36'h0, 1'b1);
        chk("R5 read 3", rd_data, 36'hA3);
        chk("R5 empty after drain", 36'(rd_ready), 36'd0);
        step(1'b0, 36'h0, 1'b1);
        chk("R11 data held on empty read", rd_data, 36'hA3);
        chk("R11 still empty", 36'(rd_ready), 36'd0);
        step(1'b1, 36'hB7, 1'b0);
        step(1'b0, 36'h0, 1'b1);
        chk("R11 pointer unmoved", rd_data, 36'hB7);
        chk("R11 empty again", 36'(rd_ready), 36'd0);
    endtask

    task automatic t_fwft;
        ae_ofs = 10'd0;
        do_reset(1'b0, 1'b0);
        chk("R8 ae_n empty fwft", 36'(ae_n), 36'd0);
        step(1'b1, 36'hC1, 1'b0);
        chk("R6 rd_ready with first word", 36'(rd_ready), 36'd1);
        chk("R6 first word shown", rd_data, 36'hC1);
        chk("R8 ae_n counts shown word", 36'(ae_n), 36'd1);
        step(1'b1, 36'hC2, 1'b0);
        step(1'b1, 36'hC3, 1'b0);
        chk("R7 head held without read", rd_data, 36'hC1);
        step(1'b1, 36'hC4, 1'b1);
        chk("R7 read+write same cycle", rd_data, 36'hC2);
        step(1'b0, 36'h0, 1'b1);
        chk("R7 next word", rd_data, 36'hC3);
        step(1'b0, 36'h0, 1'b1);
        chk("R7 last word", rd_data, 36'hC4);
        step(1'b0, 36'h0, 1'b1);
        chk("R7 drained", 36'(rd_ready), 36'd0);
        step(1'b1, 36'hC5, 1'b1);
        chk("R11 R6 write with ignored read", rd_data, 36'hC5);
        chk("R6 ready after bypass", 36'(rd_ready), 36'd1);
    endtask

    task automatic t_fill;
        ae_ofs = 10'd3; af_ofs = 10'd2;
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 1024; i++) begin
            step(1'b1, 36'(i + 'h100), 1'b0);
            if (i + 1 == 3)    chk("R8 ae_n at count 3", 36'(ae_n), 36'd0);
            if (i + 1 == 4)    chk("R8 ae_n at count 4", 36'(ae_n), 36'd1);
            if (i + 1 == 1021) chk("R9 af_n at free 3", 36'(af_n), 36'd1);
            if (i + 1 == 1022) chk("R9 af_n at free 2", 36'(af_n), 36'd0);
        end
        chk("R10 wr_ready full", 36'(wr_ready), 36'd0);
        step(1'b1, 36'hDEAD, 1'b0);
        chk("R10 still full", 36'(wr_ready), 36'd0);
        for (int i = 0; i < 1024; i++) begin
            step(1'b0, 36'h0, 1'b1);
            chk("R10 R5 data order", rd_data, 36'(i + 'h100));
        end
        chk("R10 rejected word not stored", 36'(rd_ready), 36'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_std();
        t_fwft();
        t_fill();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule